// File: doc/BRIEF.md
# Triple-Copy Memory Voting Scrubber

This block walks the address space of a memory that is kept as three identical copies. Each copy is a dual-port RAM. User logic owns the first port of each copy, and the scrubber owns the second port of all three. The contents change while the system runs, so no fixed reference image exists to scrub against. The scrubber does the following at each address:

- It reads the word from all three copies.
- It forms a bitwise two-of-three majority.
- It writes the majority back to every copy, but only when the three words are not identical.

It then moves on to the next address, wraps at the top and keeps going for as long as it is enabled.

Each address takes three cycles:

1. The address is presented.
2. The read data is captured.
3. The words are voted and compared, and the write-back happens if needed.

A saturating counter counts the addresses that were repaired. A one-cycle pulse marks each wrap back to address zero. A user write that lands on the address under scrub during its three-cycle window cancels the repair for that address. The address is then picked up again on the next pass.

Top module: `tmr_mem_scrubber`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three scrub write enables are low, the scrub address is 0, the repair count is 0 and pass_done is low.
- R2: The scrub write data driven to all three copies is the bitwise majority of the three words read at the current address. In each bit, the value held by at least two copies wins.
- R3: A word in which only one copy is corrupted, in any number of bits, is restored in that copy to the value of the other two after the scrub visits the address.
- R4: The three scrub write enables rise together, only in the third cycle of an address, and only when the three read words differ in at least one bit. Identical words cause no write.
- R5: Each address is driven on all three scrub address ports for exactly three consecutive cycles (present, capture, compare/write). The address then advances by one.
- R6: The repair count rises by exactly one for each address that is written back. It saturates at its all-ones value.
- R7: After the last address (all ones), the address wraps to 0. pass_done is high for exactly the one cycle in which address 0 is first presented again.
- R8: While scrub_en is low, no scrub write enable is raised and the address does not change. An address whose sequence was interrupted restarts at its first cycle when scrub_en returns high.
- R9: If any user write enable is high with usr_addr equal to the scrub address during any of that address's three cycles, the scrub write and the count for that address are cancelled. A remaining disagreement is repaired on the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_en | input | 1 | Scrub enable |
| usr_we | input | 3 | User port write enables, one bit per copy (bit k = copy k) |
| usr_addr | input | ADDR_W | User port write address |
| sb_addr0 | output | ADDR_W | Scrub port address, copy 0 |
| sb_addr1 | output | ADDR_W | Scrub port address, copy 1 |
| sb_addr2 | output | ADDR_W | Scrub port address, copy 2 |
| sb_rdata0 | input | DATA_W | Scrub port read data, copy 0 (one-cycle read latency) |
| sb_rdata1 | input | DATA_W | Scrub port read data, copy 1 |
| sb_rdata2 | input | DATA_W | Scrub port read data, copy 2 |
| sb_wdata0 | output | DATA_W | Scrub port write data, copy 0 |
| sb_wdata1 | output | DATA_W | Scrub port write data, copy 1 |
| sb_wdata2 | output | DATA_W | Scrub port write data, copy 2 |
| sb_we0 | output | 1 | Scrub port write enable, copy 0 |
| sb_we1 | output | 1 | Scrub port write enable, copy 1 |
| sb_we2 | output | 1 | Scrub port write enable, copy 2 |
| err_count | output | CNT_W | Saturating count of repaired addresses |
| pass_done | output | 1 | One-cycle pulse on wrap to address 0 |

## Verification
The hardest case to reach from the ports is a user write that hits the exact address under scrub inside its three-cycle window, while the copies also disagree there. The stimulus first corrupts a word in one copy. It then watches the scrub address port until that address arrives fresh, and writes a single copy at that address either in the presenting cycle or two cycles later in the write cycle. Because only one copy is written, the copies still disagree after the cancelled repair. This lets the bench confirm that the repair is skipped on this pass and happens on the next one. Saturation of the count is reached by building the bench with a narrow counter and injecting more faults than it can hold.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;

    typedef enum logic [1:0] {
        PH_ISSUE   = 2'd0,
        PH_CAPTURE = 2'd1,
        PH_WRITE   = 2'd2
    } scrub_phase_e;

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic [DATA_W-1:0] word_c,
    output logic [DATA_W-1:0] voted,
    output logic              differ
);
    logic [DATA_W-1:0] bit_diff;

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_comb begin
            voted[b]    = (word_a[b] & word_b[b]) | (word_a[b] & word_c[b]) | (word_b[b] & word_c[b]);
            bit_diff[b] = (word_a[b] ^ word_b[b]) | (word_a[b] ^ word_c[b]);
        end
    end

    assign differ = |bit_diff;
endmodule

// File: rtl/scrub_capture.sv
module scrub_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    input  logic [DATA_W-1:0] rd2,
    output logic [DATA_W-1:0] cap0,
    output logic [DATA_W-1:0] cap1,
    output logic [DATA_W-1:0] cap2
);
    typedef struct packed {
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w1;
        logic [DATA_W-1:0] w2;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.w0 = rd0;
            cap_d.w1 = rd1;
            cap_d.w2 = rd2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap0 = cap_q.w0;
    assign cap1 = cap_q.w1;
    assign cap2 = cap_q.w2;
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
    import tmr_scrub_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              usr_hit,
    input  logic              differ,
    output logic [ADDR_W-1:0] addr,
    output logic              cap_load,
    output logic              wr_go,
    output logic              pass_pulse
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        scrub_phase_e      phase;
        logic [ADDR_W-1:0] addr;
        logic              hit;
        logic              pass;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.pass = 1'b0;
        cap_load   = 1'b0;
        wr_go      = 1'b0;
        if (!en) begin
            seq_d.phase = PH_ISSUE;
            seq_d.hit   = 1'b0;
        end else begin
            unique case (seq_q.phase)
                PH_ISSUE: begin
                    seq_d.phase = PH_CAPTURE;
                    seq_d.hit   = seq_q.hit | usr_hit;
                end
                PH_CAPTURE: begin
                    cap_load    = 1'b1;
                    seq_d.phase = PH_WRITE;
                    seq_d.hit   = seq_q.hit | usr_hit;
                end
                PH_WRITE: begin
                    wr_go       = differ & ~(seq_q.hit | usr_hit);
                    seq_d.phase = PH_ISSUE;
                    seq_d.hit   = 1'b0;
                    seq_d.addr  = seq_q.addr + 1'b1;
                    seq_d.pass  = (seq_q.addr == LAST_ADDR);
                end
                default: begin
                    seq_d.phase = PH_ISSUE;
                    seq_d.hit   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.phase <= PH_ISSUE;
            seq_q.addr  <= '0;
            seq_q.hit   <= 1'b0;
            seq_q.pass  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr       = seq_q.addr;
    assign pass_pulse = seq_q.pass;

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.addr != $past(seq_q.addr)) |-> (seq_q.addr == $past(seq_q.addr) + 1'b1));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(seq_q.addr));

    // R4
    write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (seq_q.phase == PH_WRITE) && $past(seq_q.phase == PH_CAPTURE));
endmodule

// File: rtl/scrub_errcnt.sv
module scrub_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1) && $past(bump));

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/tmr_mem_scrubber.sv
module tmr_mem_scrubber #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_en,
    input  logic [2:0]        usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic [ADDR_W-1:0] sb_addr0,
    output logic [ADDR_W-1:0] sb_addr1,
    output logic [ADDR_W-1:0] sb_addr2,
    input  logic [DATA_W-1:0] sb_rdata0,
    input  logic [DATA_W-1:0] sb_rdata1,
    input  logic [DATA_W-1:0] sb_rdata2,
    output logic [DATA_W-1:0] sb_wdata0,
    output logic [DATA_W-1:0] sb_wdata1,
    output logic [DATA_W-1:0] sb_wdata2,
    output logic              sb_we0,
    output logic              sb_we1,
    output logic              sb_we2,
    output logic [CNT_W-1:0]  err_count,
    output logic              pass_done
);
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cap0, cap1, cap2, voted;
    logic              differ, cap_load, wr_go, usr_hit;

    assign usr_hit = (|usr_we) && (usr_addr == cur_addr);

    scrub_seq #(.ADDR_W(ADDR_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (scrub_en),
        .usr_hit    (usr_hit),
        .differ     (differ),
        .addr       (cur_addr),
        .cap_load   (cap_load),
        .wr_go      (wr_go),
        .pass_pulse (pass_done)
    );

    scrub_capture #(.DATA_W(DATA_W)) i_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_load),
        .rd0   (sb_rdata0),
        .rd1   (sb_rdata1),
        .rd2   (sb_rdata2),
        .cap0  (cap0),
        .cap1  (cap1),
        .cap2  (cap2)
    );

    tmr_vote #(.DATA_W(DATA_W)) i_vote (
        .word_a (cap0),
        .word_b (cap1),
        .word_c (cap2),
        .voted  (voted),
        .differ (differ)
    );

    scrub_errcnt #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (wr_go),
        .count (err_count)
    );

    assign sb_addr0  = cur_addr;
    assign sb_addr1  = cur_addr;
    assign sb_addr2  = cur_addr;
    assign sb_wdata0 = voted;
    assign sb_wdata1 = voted;
    assign sb_wdata2 = voted;
    assign sb_we0    = wr_go;
    assign sb_we1    = wr_go;
    assign sb_we2    = wr_go;

    // R7
    pass_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (sb_addr0 == '0) && $past(sb_addr0 == {ADDR_W{1'b1}}));

    // R9
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_we0 |-> !((|usr_we) && (usr_addr == sb_addr0)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scrub_en |-> !(sb_we0 || sb_we1 || sb_we2));

    // R2
    wdata_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_we0 |-> (((sb_wdata0 ^ cap0) & (sb_wdata0 ^ cap1)) == '0) &&
                   (((sb_wdata0 ^ cap1) & (sb_wdata0 ^ cap2)) == '0));
endmodule

// File: tb/test_tmr_mem_scrubber.sv
module test_tmr_mem_scrubber;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CW = 3;
    localparam int N  = 1 << AW;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scrub_en = 1'b0;
    logic [2:0] usr_we = 3'b000;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic [AW-1:0] sb_addr0, sb_addr1, sb_addr2;
    logic [DW-1:0] rd0 = '0, rd1 = '0, rd2 = '0;
    logic [DW-1:0] sb_wdata0, sb_wdata1, sb_wdata2;
    logic sb_we0, sb_we1, sb_we2, pass_done;
    logic [CW-1:0] err_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0] m0 [N];
    logic [DW-1:0] m1 [N];
    logic [DW-1:0] m2 [N];
    logic [DW-1:0] gold [N];

    // reference model state
    int ref_ph = 0, ref_a = 0, ref_err = 0;
    bit ref_hit = 0, ref_pass = 0;
    logic [DW-1:0] s0 = '0, s1 = '0, s2 = '0;

    always #2 clk = ~clk;

    tmr_mem_scrubber #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_tmr_mem_scrubber (
        .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .usr_we(usr_we), .usr_addr(usr_addr),
        .sb_addr0(sb_addr0), .sb_addr1(sb_addr1), .sb_addr2(sb_addr2),
        .sb_rdata0(rd0), .sb_rdata1(rd1), .sb_rdata2(rd2),
        .sb_wdata0(sb_wdata0), .sb_wdata1(sb_wdata1), .sb_wdata2(sb_wdata2),
        .sb_we0(sb_we0), .sb_we1(sb_we1), .sb_we2(sb_we2),
        .err_count(err_count), .pass_done(pass_done)
    );

    function automatic logic [DW-1:0] maj(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
        return r;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic bit uhit_now();
        return (usr_we != 3'b000) && (int'(usr_addr) == ref_a);
    endfunction

    function automatic bit exp_we();
        return scrub_en && ref_ph == 2 && !(s0 == s1 && s1 == s2) && !(ref_hit || uhit_now());
    endfunction

    // memories and reference model, updated on the clock edge
    always @(posedge clk) begin
        bit w;
        cycles++;
        rd0 <= m0[sb_addr0];
        rd1 <= m1[sb_addr1];
        rd2 <= m2[sb_addr2];
        if (!rst_n) begin
            ref_ph = 0; ref_a = 0; ref_err = 0; ref_hit = 0; ref_pass = 0;
        end else begin
            w = exp_we();
            ref_pass = 0;
            if (!scrub_en) begin
                ref_ph = 0; ref_hit = 0;
            end else if (ref_ph == 0) begin
                s0 = m0[ref_a]; s1 = m1[ref_a]; s2 = m2[ref_a];
                ref_hit = ref_hit || uhit_now();
                ref_ph = 1;
            end else if (ref_ph == 1) begin
                ref_hit = ref_hit || uhit_now();
                ref_ph = 2;
            end else begin
                if (w && ref_err < CMAX) ref_err++;
                ref_pass = (ref_a == N - 1);
                ref_a = (ref_a + 1) % N;
                ref_ph = 0; ref_hit = 0;
            end
        end
        if (sb_we0) m0[sb_addr0] = sb_wdata0;
        if (sb_we1) m1[sb_addr1] = sb_wdata1;
        if (sb_we2) m2[sb_addr2] = sb_wdata2;
        if (usr_we[0]) m0[usr_addr] = usr_wdata;
        if (usr_we[1]) m1[usr_addr] = usr_wdata;
        if (usr_we[2]) m2[usr_addr] = usr_wdata;
    end

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit e;
            e = exp_we();
            chk(sb_addr0 == ref_a && sb_addr1 == ref_a && sb_addr2 == ref_a, "R5 address", int'(sb_addr0), ref_a);
            chk(sb_we0 == e && sb_we1 == e && sb_we2 == e, "R4 write enable", int'(sb_we0), int'(e));
            if (e) chk(sb_wdata0 == maj(s0, s1, s2) && sb_wdata1 == sb_wdata0 && sb_wdata2 == sb_wdata0,
                       "R2 voted data", int'(sb_wdata0), int'(maj(s0, s1, s2)));
            chk(int'(err_count) == ref_err, "R6 repair count", int'(err_count), ref_err);
            chk(pass_done == ref_pass, "R7 pass_done", int'(pass_done), int'(ref_pass));
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_all_gold(string req);
        int bad;
        bad = 0;
        for (int i = 0; i < N; i++)
            if (m0[i] != gold[i] || m1[i] != gold[i] || m2[i] != gold[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic wait_fresh(int a);
        while (int'(sb_addr0) == a) @(negedge clk);
        while (int'(sb_addr0) != a) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            gold[i] = DW'(i * 37 + 5);
            m0[i] = gold[i]; m1[i] = gold[i]; m2[i] = gold[i];
        end
        wait_cyc(3);
        // R1: reset state
        chk(sb_we0 == 0 && sb_we1 == 0 && sb_we2 == 0, "R1 we in reset", int'(sb_we0), 0);
        chk(sb_addr0 == 0 && err_count == 0 && pass_done == 0, "R1 reset outputs", int'(err_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sb_addr0 == 0 && err_count == 0 && pass_done == 0 && sb_we0 == 0, "R1 after reset", int'(sb_addr0), 0);

        // clean pass: no writes
        scrub_en = 1'b1;
        wait_cyc(3 * N + 2);
        chk(err_count == 0, "R4 clean pass no repair", int'(err_count), 0);

        // R7 and R5: pass period
        begin
            int c;
            while (!pass_done) @(negedge clk);
            c = 0;
            @(negedge clk);
            while (!pass_done) begin c++; @(negedge clk); end
            chk(c + 1 == 3 * N, "R7 pass period", c + 1, 3 * N);
            chk(sb_addr0 == 0, "R7 wrap to zero", int'(sb_addr0), 0);
        end

        // R3: single-copy faults
        m0[3] = m0[3] ^ 8'h01;
        m1[5] = m1[5] ^ 8'hA5;
        m2[9] = m2[9] ^ 8'hFF;
        // R2: different bits wrong in different copies of one word
        m0[12] = m0[12] ^ 8'h10;
        m1[12] = m1[12] ^ 8'h02;
        wait_cyc(3 * N + 3);
        check_all_gold("R3 single copy repaired");
        chk(err_count == 4, "R6 count after repairs", int'(err_count), 4);

        // R2: two copies agree on a wrong value, vote follows them
        m1[7] = m1[7] ^ 8'h40;
        m2[7] = m2[7] ^ 8'h40;
        gold[7] = gold[7] ^ 8'h40;
        wait_cyc(3 * N + 3);
        check_all_gold("R2 majority of two wins");

        // R8: disable holds address and blocks writes
        m2[1] = m2[1] ^ 8'h08;
        m2[2] = m2[2] ^ 8'h08;
        m2[11] = m2[11] ^ 8'h08;
        wait_cyc(4);
        scrub_en = 1'b0;
        begin
            logic [AW-1:0] held;
            int c0;
            held = sb_addr0;
            c0 = int'(err_count);
            wait_cyc(20);
            chk(sb_addr0 == held, "R8 address held", int'(sb_addr0), int'(held));
            chk(int'(err_count) == c0, "R8 no repair while idle", int'(err_count), c0);
        end
        scrub_en = 1'b1;
        wait_cyc(2);
        scrub_en = 1'b0;
        wait_cyc(3);
        scrub_en = 1'b1;
        wait_cyc(2 * 3 * N);
        check_all_gold("R8 repairs resume");

        // R9: collision in the presenting cycle, then in the write cycle
        m1[6] = m1[6] ^ 8'h20;
        wait_fresh(6);
        usr_we = 3'b001; usr_addr = 4'd6; usr_wdata = gold[6];
        @(negedge clk);
        usr_we = 3'b000;
        begin
            int c0;
            c0 = int'(err_count);
            wait_cyc(3);
            chk(m1[6] != gold[6] && int'(err_count) == c0, "R9 cancelled on issue hit", int'(m1[6]), int'(gold[6] ^ 8'h20));
        end
        m0[10] = m0[10] ^ 8'h04;
        wait_fresh(10);
        wait_cyc(2);
        usr_we = 3'b100; usr_addr = 4'd10; usr_wdata = gold[10];
        @(negedge clk);
        usr_we = 3'b000;
        chk(m0[10] != gold[10], "R9 cancelled on write hit", int'(m0[10]), int'(gold[10] ^ 8'h04));
        wait_cyc(3 * N + 3);
        check_all_gold("R9 retried next pass");

        // R6: saturation
        for (int i = 0; i < 10; i++) m0[i] = m0[i] ^ 8'h80;
        wait_cyc(3 * N + 3);
        chk(int'(err_count) == CMAX, "R6 saturation", int'(err_count), CMAX);
        check_all_gold("R3 repairs under saturation");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule